// File: doc/BRIEF.md
# External Clock Sync Detector

This block picks the timing source for a PWM controller's switching cycle. A free-running counter sets the cycle at a programmed nominal period. An external sync pin can take over that role. The pin is sampled on a fast clock and passed through a two-flop synchroniser. Each high pulse must pass two tests before it counts. Its width must exceed a minimum number of samples, and the interval since the previous accepted pulse must lie inside a ±10% window around the nominal period.

Entry to synchronised mode and exit from it are hysteretic. Three accepted pulses in a row with in-window spacing lock the block onto the pin. After that, every accepted pulse issues a cycle-start strobe. An expected pulse that does not arrive, or one with a bad interval, counts as a miss. Each miss still issues a stand-in strobe, so switching does not stop. Eight misses in a row return the block to the internal counter. A square-wave clock output always follows the internal counter, so other controllers can use it as their sync source.

Top module: `sync_det`

## Requirements
- R1: While reset is held and just after it is released, `sync_mode` is 0, `cycle_start` is 0 and `clk_out` is 1.
- R2: In free-run mode, `cycle_start` pulses for one clock once every NOM_PERIOD clocks, and `clk_out` is high for NOM_PERIOD/2 clocks of each period. This holds when the pin is held low.
- R3: In free-run mode, `clk_out` is 0 in the clock that carries a `cycle_start` pulse and rises in the next clock.
- R4: Three consecutive accepted pulses lock the block, and `sync_mode` goes to 1. The first pulse after idle needs no interval. The second and third must each be in window relative to the one before. Two pulses alone leave `sync_mode` at 0.
- R5: A pulse is accepted only if the synchronised pin stays high for at least MIN_HIGH+1 consecutive samples. A narrower pulse is ignored completely: it neither restarts the interval measurement nor touches the lock count.
- R6: An interval is in window when it lies between NOM_PERIOD−NOM_PERIOD/10 and NOM_PERIOD+NOM_PERIOD/10 clocks, both bounds included. With the defaults this is 90 to 110.
- R7: An accepted pulse with an out-of-window interval restarts the lock count. That pulse becomes the first of a new run of three.
- R8: In sync mode, `cycle_start` gives exactly one pulse per accepted in-window pulse, at the pin's rate, not at the internal rate.
- R9: In sync mode, if no accepted pulse arrives within NOM_PERIOD+NOM_PERIOD/10 clocks of the expected slot, a stand-in `cycle_start` is issued. The interval reference then advances by NOM_PERIOD, so a pulse that arrives on the original grid is still in window.
- R10: Eight consecutive misses return `sync_mode` to 0, and free-run strobes follow. Seven misses followed by an on-grid pulse keep `sync_mode` at 1.
- R11: A pin held high gives no lock, and the block keeps free-run timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External sync pin, asynchronous |
| cycle_start | output | 1 | One-clock strobe that begins a PWM cycle |
| sync_mode | output | 1 | 1 when locked to the sync pin, 0 in free-run |
| clk_out | output | 1 | Square wave from the internal counter, for slave controllers |

## Verification
The lock logic is driven with pulse trains whose interval sits at the nominal value, on each window bound, and one clock beyond each bound. This separates an inclusive window from an exclusive one. Pulse widths of exactly MIN_HIGH and MIN_HIGH+1 samples test the strict width rule. Narrow glitches placed inside a valid train show whether rejected pulses disturb the interval reference. In sync mode, a train at 108 clocks is counted against the internal 100-clock rate to tell the two sources apart. Gaps of three, seven and eight missing pulses separate stand-in strobes, kept lock and fallback.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } clk_mode_e;

    // One-clock strobes from the pulse qualifier
    typedef struct packed {
        logic good;   // accepted pulse, interval in window
        logic bad;    // accepted pulse, interval out of window
        logic late;   // expected pulse overdue (sync mode only)
    } pulse_evt_t;

    function automatic int win_lo(input int nom, input int div);
        return nom - nom / div;
    endfunction

    function automatic int win_hi(input int nom, input int div);
        return nom + nom / div;
    endfunction

endpackage

// File: rtl/sync_det_osc.sv
module sync_det_osc #(
    parameter int NOM_PERIOD = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic clk_out
);
    localparam int OSC_W = $clog2(NOM_PERIOD);
    localparam logic [OSC_W-1:0] LAST = OSC_W'(NOM_PERIOD - 1);
    localparam logic [OSC_W-1:0] HALF = OSC_W'(NOM_PERIOD / 2);

    logic [OSC_W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            clk_out <= 1'b1;
        end else begin
            cnt     <= tick ? '0 : cnt + 1'b1;
            clk_out <= (cnt < HALF);
        end
    end
endmodule

// File: rtl/sync_det_qual.sv
module sync_det_qual
    import sync_det_pkg::*;
#(
    parameter int NOM_PERIOD = 100,
    parameter int MIN_HIGH   = 8,
    parameter int WIN_LO     = 90,
    parameter int WIN_HI     = 110,
    parameter int PER_W      = 9,
    parameter int HI_W       = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic       track,
    output pulse_evt_t evt
);
    localparam logic [HI_W-1:0]  HI_QUAL = HI_W'(MIN_HIGH);
    localparam logic [PER_W-1:0] LO_V    = PER_W'(WIN_LO);
    localparam logic [PER_W-1:0] HI_V    = PER_W'(WIN_HI);
    localparam logic [PER_W-1:0] LATE_V  = PER_W'(WIN_HI + 1);
    localparam logic [PER_W-1:0] REWIND  = PER_W'(NOM_PERIOD - 1);

    logic             s1, s2;
    logic [HI_W-1:0]  hi_cnt;
    logic [PER_W-1:0] per_cnt;
    logic             qual, in_win, late;

    assign qual   = s2 && (hi_cnt == HI_QUAL);
    assign in_win = (per_cnt >= LO_V) && (per_cnt <= HI_V);
    assign late   = track && !qual && (per_cnt == LATE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            hi_cnt  <= '0;
            per_cnt <= '1;
            evt     <= '0;
        end else begin
            s1 <= sync_in;
            s2 <= s1;
            if (!s2)
                hi_cnt <= '0;
            else if (hi_cnt <= HI_QUAL)
                hi_cnt <= hi_cnt + 1'b1;
            if (qual)
                per_cnt <= PER_W'(1);
            else if (late)
                per_cnt <= per_cnt - REWIND;
            else if (per_cnt != '1)
                per_cnt <= per_cnt + 1'b1;
            evt.good <= qual && in_win;
            evt.bad  <= qual && !in_win;
            evt.late <= late;
        end
    end
endmodule

// File: rtl/sync_det_fsm.sv
module sync_det_fsm
    import sync_det_pkg::*;
#(
    parameter int LOCK_EDGES = 3,
    parameter int MISS_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  pulse_evt_t evt,
    output logic       sync_mode,
    output logic       miss_evt
);
    localparam int LK_W = $clog2(LOCK_EDGES + 1);
    localparam int MS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [LK_W-1:0] LOCK_LAST = LK_W'(LOCK_EDGES - 1);
    localparam logic [MS_W-1:0] MISS_LAST = MS_W'(MISS_LIMIT - 1);

    clk_mode_e       mode;
    logic [LK_W-1:0] lock_cnt;
    logic [MS_W-1:0] miss_cnt;

    assign sync_mode = (mode == MODE_SYNC);
    assign miss_evt  = sync_mode && (evt.bad || evt.late);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_FREE;
            lock_cnt <= '0;
            miss_cnt <= '0;
        end else begin
            case (mode)
                MODE_FREE: begin
                    if (evt.good) begin
                        if (lock_cnt == LOCK_LAST) begin
                            mode     <= MODE_SYNC;
                            lock_cnt <= '0;
                            miss_cnt <= '0;
                        end else begin
                            lock_cnt <= lock_cnt + 1'b1;
                        end
                    end else if (evt.bad) begin
                        lock_cnt <= LK_W'(1);
                    end
                end
                MODE_SYNC: begin
                    if (evt.good) begin
                        miss_cnt <= '0;
                    end else if (miss_evt) begin
                        if (miss_cnt == MISS_LAST) begin
                            mode     <= MODE_FREE;
                            miss_cnt <= '0;
                            lock_cnt <= '0;
                        end else begin
                            miss_cnt <= miss_cnt + 1'b1;
                        end
                    end
                end
                default: mode <= MODE_FREE;
            endcase
        end
    end
endmodule

// File: rtl/sync_det.sv
module sync_det
    import sync_det_pkg::*;
#(
    parameter int NOM_PERIOD = 100,
    parameter int TOL_DIV    = 10,
    parameter int MIN_HIGH   = 8,
    parameter int LOCK_EDGES = 3,
    parameter int MISS_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic cycle_start,
    output logic sync_mode,
    output logic clk_out
);
    localparam int WIN_LO = win_lo(NOM_PERIOD, TOL_DIV);
    localparam int WIN_HI = win_hi(NOM_PERIOD, TOL_DIV);
    localparam int PER_W  = $clog2(4 * NOM_PERIOD);
    localparam int HI_W   = $clog2(MIN_HIGH + 2);

    pulse_evt_t evt;
    logic       osc_tick;
    logic       miss_evt;

    sync_det_osc #(.NOM_PERIOD(NOM_PERIOD)) u_osc (
        .clk(clk), .rst(rst), .tick(osc_tick), .clk_out(clk_out)
    );

    sync_det_qual #(
        .NOM_PERIOD(NOM_PERIOD), .MIN_HIGH(MIN_HIGH),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PER_W(PER_W), .HI_W(HI_W)
    ) u_qual (
        .clk(clk), .rst(rst), .sync_in(sync_in), .track(sync_mode), .evt(evt)
    );

    sync_det_fsm #(.LOCK_EDGES(LOCK_EDGES), .MISS_LIMIT(MISS_LIMIT)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .sync_mode(sync_mode), .miss_evt(miss_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cycle_start <= 1'b0;
        else
            cycle_start <= sync_mode ? (evt.good || miss_evt) : osc_tick;
    end
endmodule

// File: rtl/sync_det_chk.sv
module sync_det_chk (
    input logic clk,
    input logic rst,
    input logic sync_mode,
    input logic cycle_start,
    input logic clk_out,
    input logic good,
    input logic miss_evt,
    input logic osc_tick
);
    // R4: lock only follows an accepted in-window pulse
    p_lock_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_mode) |-> $past(good));

    // R10: fallback only follows a miss event
    p_exit_src_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_mode) |-> $past(miss_evt));

    // R3: square wave rises two clocks after the internal counter wraps
    p_clk_align_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> $past(osc_tick, 2));

    // R2: free-run strobes come from the internal counter only
    p_free_src_r2: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && !$past(sync_mode)) |-> $past(osc_tick));

    // R8: sync-mode strobes come from accepted pulses or stand-ins only
    p_sync_src_r8: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && $past(sync_mode)) |-> $past(good || miss_evt));
endmodule

bind sync_det sync_det_chk u_chk (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .cycle_start(cycle_start),
    .clk_out(clk_out), .good(evt.good), .miss_evt(miss_evt), .osc_tick(osc_tick)
);

// File: tb/tb_sync_det.sv
`timescale 1ns/1ps
module tb_sync_det;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic cycle_start, sync_mode, clk_out;

    int n_run  = 0;
    int n_fail = 0;
    int st_cnt = 0;
    int hi_cnt = 0;
    logic counting = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    sync_det dut (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .cycle_start(cycle_start), .sync_mode(sync_mode), .clk_out(clk_out)
    );

    // {interval, high width, pulses, expected sync_mode}
    localparam int VEC [9][4] = '{
        '{100, 20, 3, 1},
        '{100, 20, 2, 0},
        '{ 90, 20, 3, 1},
        '{110, 20, 3, 1},
        '{ 89, 20, 5, 0},
        '{111, 20, 5, 0},
        '{100,  9, 3, 1},
        '{100,  8, 5, 0},
        '{ 95, 40, 4, 1}
    };

    always @(negedge clk) begin
        #1;
        if (counting) begin
            if (cycle_start) st_cnt++;
            if (clk_out) hi_cnt++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n, input logic lvl);
        sync_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int per, input int wid);
        sync_in = 1'b1;
        repeat (wid) @(negedge clk);
        sync_in = 1'b0;
        repeat (per - wid) @(negedge clk);
    endtask

    task automatic glitch_send(input int per);
        sync_in = 1'b1; repeat (20) @(negedge clk);
        sync_in = 1'b0; repeat (30) @(negedge clk);
        sync_in = 1'b1; repeat (3) @(negedge clk);
        sync_in = 1'b0; repeat (per - 53) @(negedge clk);
    endtask

    task automatic start_count();
        st_cnt = 0; hi_cnt = 0; counting = 1'b1;
    endtask

    task automatic lock_fresh();
        idle(1200, 1'b0);
        for (int k = 0; k < 3; k++) send(100, 20);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R1 sync_mode after reset", sync_mode, 0);
        check("R1 cycle_start after reset", cycle_start, 0);
        check("R1 clk_out after reset", clk_out, 1);

        // R2: free-run rate and duty with pin low
        idle(50, 1'b0);
        start_count(); idle(1000, 1'b0); counting = 1'b0;
        check("R2 free-run strobes in 1000", st_cnt, 10);
        check("R2 clk_out high clocks in 1000", hi_cnt, 500);

        // R3: clk_out rises one clock after a free-run strobe
        while (!cycle_start) @(negedge clk);
        check("R3 clk_out low at strobe", clk_out, 0);
        @(negedge clk);
        check("R3 clk_out high after strobe", clk_out, 1);

        // R4 R5 R6 table: lock count, width rule, interval window
        for (int i = 0; i < 9; i++) begin
            idle(1200, 1'b0);
            for (int k = 0; k < VEC[i][2]; k++) send(VEC[i][0], VEC[i][1]);
            check($sformatf("R4 R5 R6 row %0d", i), sync_mode, VEC[i][3]);
        end

        // R5: narrow glitches inside a valid train are ignored
        idle(1200, 1'b0);
        glitch_send(100); glitch_send(100); send(100, 20);
        check("R5 glitches ignored, lock reached", sync_mode, 1);

        // R7: out-of-window interval restarts the run
        idle(1200, 1'b0);
        send(100, 20); send(60, 20); send(100, 20); send(100, 20);
        check("R7 not locked after restart plus one", sync_mode, 0);
        send(100, 20);
        check("R7 locked on third after restart", sync_mode, 1);

        // R8: strobes follow the pin rate
        lock_fresh();
        start_count();
        for (int k = 0; k < 20; k++) send(108, 20);
        counting = 1'b0;
        check("R8 strobes for 20 pulses at 108", st_cnt, 20);
        check("R8 still locked", sync_mode, 1);

        // R9: stand-in strobes for missing pulses
        lock_fresh();
        start_count();
        idle(300, 1'b0);
        for (int k = 0; k < 5; k++) send(100, 20);
        counting = 1'b0;
        check("R9 strobes with 3 missing plus 5 pulses", st_cnt, 8);
        check("R9 lock kept", sync_mode, 1);

        // R10: seven misses keep lock, eight drop it
        idle(700, 1'b0); send(100, 20);
        check("R10 lock kept after 7 misses", sync_mode, 1);
        idle(1000, 1'b0);
        check("R10 free-run after 8 misses", sync_mode, 0);
        start_count(); idle(1000, 1'b0); counting = 1'b0;
        check("R10 free-run strobes after fallback", st_cnt, 10);

        // R11: pin held high
        idle(200, 1'b1);
        start_count(); idle(1000, 1'b1); counting = 1'b0;
        check("R11 no lock with pin high", sync_mode, 0);
        check("R11 free-run strobes with pin high", st_cnt, 10);
        sync_in = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule